// File: doc/BRIEF.md
# Global Error Logging Register Bank

This block is a bank of 64-bit registers that gathers error indications for a device management engine. Five independent sources feed it, each as a vector of one-cycle error pulses, and each source has its own mask. Three sources are sticky logs cleared by software: the general engine source and two link sources. The other two are read-only status groups: a non-fatal group and a catastrophic/fatal group. A small capture machine records the first and the next newly logged error among the sticky sources. A three-bit injection code lets software raise test pulses in the status groups. An aggregate flag is high whenever any error is logged.

Software reaches the bank through a plain register port: a write strobe with a byte address and 64-bit data, and a combinational read of the addressed register. A sticky error is cleared by writing back the value just read, because each 1 written clears that bit. The capture machine has four named states. CAP_EMPTY means nothing is held. CAP_ONE means a first error is held. CAP_TWO means both first and next are held. CAP_LATE means the first error was released while the next is still held. The transitions are arm (EMPTY→ONE on a new logged bit), follow (ONE→TWO on a further new bit), drop_first (ONE→EMPTY), drop_next (TWO→ONE), drop_both (TWO→EMPTY), orphan (TWO→LATE) and drain (LATE→EMPTY).

Top module: `gerr_bank`

## Requirements
- R1: After reset all five mask registers read all ones, all error, first, next and injection registers read zero, and `err_any` is 0.
- R2: The registers sit at these byte addresses: engine mask 0x08 / log 0x10, link0 mask 0x18 / log 0x20, link1 mask 0x28 / log 0x30, first 0x38, next 0x40, non-fatal mask 0x48 / status 0x50, fatal mask 0x58 / status 0x60, injection 0x68. Any other address reads zero.
- R3: A mask register takes the written value at the clock edge. An event bit is logged only where the mask bit stored before that edge is 0.
- R4: On an edge, a sticky log register becomes (old AND NOT written-ones) OR (unmasked events). A write to it therefore clears exactly the written 1 bits, and an event on the same bit in the same cycle wins over the clear.
- R5: With parameter REV at 0, bit SPECIAL (6) of the engine mask always reads 1, so engine events on that bit are never logged.
- R6: The non-fatal and fatal status registers hold, one edge later, (events OR injected pulses) AND NOT mask. Software writes to them have no effect.
- R7: The injection register stores and reads back all 64 bits. Code bit 0 pulses non-fatal bit 0, code bit 1 pulses fatal bit 0 and code bit 2 pulses fatal bit 1, on every cycle the code bit is set.
- R8: In CAP_EMPTY, the first new logged bit of any sticky source is captured into the first register. The lowest-numbered source wins (engine 0, link0 1, link1 2), then the lowest bit. The word holds a 1 at bit 61+source and the bit index in bits [5:0]. Other bits newly logged in the same cycle are not recorded.
- R9: In CAP_ONE, a new logged bit captures into the next register in the same format, unless the first is released in that cycle.
- R10: A held first or next word is released on the edge after its recorded log bit reads 0. A new first is armed only when both registers are empty, so nothing is captured in CAP_TWO or CAP_LATE.
- R11: `err_any` is 1 exactly when any of the five error/status registers is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_eng | input | DW | Engine error pulses |
| ev_lnk0 | input | DW | Link 0 error pulses |
| ev_lnk1 | input | DW | Link 1 error pulses |
| ev_nf | input | DW | Non-fatal group error pulses |
| ev_cf | input | DW | Catastrophic/fatal group error pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the addressed register |
| err_any | output | 1 | Any error or status bit set |

## Verification
The bench targets a clear and an event that land on the same bit in the same edge. A design that let the clear win would drop a real error and release the first word too early. It also sends simultaneous new bits from several sources, where a wrong priority encoder would report the wrong source or bit index, or would sneak a second error into the next register. The CAP_LATE path is exercised by clearing the first error while the next is still held and then raising fresh events. A design that re-armed early would capture them. Writes to the read-only status registers and attempts to unmask the engine's special bit are followed by reads and events that would expose any change they made.

// File: rtl/gerr_pkg.sv
`timescale 1ns/1ps
package gerr_pkg;

    typedef enum logic [1:0] {
        CAP_EMPTY,
        CAP_ONE,
        CAP_TWO,
        CAP_LATE
    } cap_state_e;

    localparam int NSTK = 3;
    localparam int NSTS = 2;

    localparam logic [7:0] A_STK_MASK0 = 8'h08;
    localparam logic [7:0] A_STK_LOG0  = 8'h10;
    localparam logic [7:0] A_FIRST     = 8'h38;
    localparam logic [7:0] A_NEXT      = 8'h40;
    localparam logic [7:0] A_STS_MASK0 = 8'h48;
    localparam logic [7:0] A_STS_VAL0  = 8'h50;
    localparam logic [7:0] A_INJ       = 8'h68;
    localparam int         A_STRIDE    = 16;

    function automatic logic [7:0] stk_mask_addr(input int s);
        return A_STK_MASK0 + 8'(s * A_STRIDE);
    endfunction

    function automatic logic [7:0] stk_log_addr(input int s);
        return A_STK_LOG0 + 8'(s * A_STRIDE);
    endfunction

    function automatic logic [7:0] sts_mask_addr(input int s);
        return A_STS_MASK0 + 8'(s * A_STRIDE);
    endfunction

    function automatic logic [7:0] sts_val_addr(input int s);
        return A_STS_VAL0 + 8'(s * A_STRIDE);
    endfunction

endpackage

// File: rtl/gerr_log.sv
`timescale 1ns/1ps
module gerr_log #(
    parameter int             DW    = 64,
    parameter logic [DW-1:0]  FORCE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic          clr_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ev,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] log_q,
    output logic [DW-1:0] new_bits
);

    logic [DW-1:0] hit;
    logic [DW-1:0] clr;

    assign hit      = ev & ~mask_q;
    assign clr      = clr_we ? wdata : '0;
    assign new_bits = hit & ~log_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= wdata | FORCE;
        end
    end

    // set wins over clear on the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= (log_q & ~clr) | hit;
        end
    end

endmodule

// File: rtl/gerr_stat.sv
`timescale 1ns/1ps
module gerr_stat #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ev,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] sts_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            sts_q  <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata;
            end
            sts_q <= ev & ~mask_q;
        end
    end

endmodule

// File: rtl/gerr_capture.sv
`timescale 1ns/1ps
module gerr_capture
    import gerr_pkg::*;
#(
    parameter int DW = 64,
    parameter int NS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NS-1:0][DW-1:0] new_bits,
    input  logic [NS-1:0][DW-1:0] log_q,
    output logic [DW-1:0]         first_word,
    output logic [DW-1:0]         next_word
);

    localparam int IW = $clog2(DW);
    localparam int SW = (NS > 1) ? $clog2(NS) : 1;

    cap_state_e     state_q, state_d;
    logic [SW-1:0]  fsrc_q, nsrc_q, psrc;
    logic [IW-1:0]  fidx_q, nidx_q, pidx;
    logic           any_new;
    logic           rel_f, rel_n;
    logic           load_f, load_n;

    // priority pick: lowest source, then lowest bit
    always_comb begin
        any_new = 1'b0;
        psrc    = '0;
        pidx    = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (|new_bits[s]) begin
                any_new = 1'b1;
                psrc    = SW'(s);
            end
        end
        for (int b = DW - 1; b >= 0; b--) begin
            if (new_bits[psrc][b]) begin
                pidx = IW'(b);
            end
        end
    end

    assign rel_f = ~log_q[fsrc_q][fidx_q];
    assign rel_n = ~log_q[nsrc_q][nidx_q];

    always_comb begin
        state_d = state_q;
        load_f  = 1'b0;
        load_n  = 1'b0;
        unique case (state_q)
            CAP_EMPTY: begin
                if (any_new) begin
                    state_d = CAP_ONE;
                    load_f  = 1'b1;
                end
            end
            CAP_ONE: begin
                if (rel_f) begin
                    state_d = CAP_EMPTY;
                end else if (any_new) begin
                    state_d = CAP_TWO;
                    load_n  = 1'b1;
                end
            end
            CAP_TWO: begin
                if (rel_f && rel_n) begin
                    state_d = CAP_EMPTY;
                end else if (rel_f) begin
                    state_d = CAP_LATE;
                end else if (rel_n) begin
                    state_d = CAP_ONE;
                end
            end
            CAP_LATE: begin
                if (rel_n) begin
                    state_d = CAP_EMPTY;
                end
            end
            default: state_d = CAP_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsrc_q <= '0;
            fidx_q <= '0;
            nsrc_q <= '0;
            nidx_q <= '0;
        end else begin
            if (load_f) begin
                fsrc_q <= psrc;
                fidx_q <= pidx;
            end
            if (load_n) begin
                nsrc_q <= psrc;
                nidx_q <= pidx;
            end
        end
    end

    always_comb begin
        first_word = '0;
        next_word  = '0;
        unique case (state_q)
            CAP_ONE, CAP_TWO: begin
                first_word[DW-NS+int'(fsrc_q)] = 1'b1;
                first_word[IW-1:0]             = fidx_q;
            end
            default: ;
        endcase
        unique case (state_q)
            CAP_TWO, CAP_LATE: begin
                next_word[DW-NS+int'(nsrc_q)] = 1'b1;
                next_word[IW-1:0]             = nidx_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gerr_bank.sv
`timescale 1ns/1ps
module gerr_bank
    import gerr_pkg::*;
#(
    parameter int DW      = 64,
    parameter int AW      = 8,
    parameter int REV     = 0,
    parameter int SPECIAL = 6,
    parameter int INJ_W   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_eng,
    input  logic [DW-1:0] ev_lnk0,
    input  logic [DW-1:0] ev_lnk1,
    input  logic [DW-1:0] ev_nf,
    input  logic [DW-1:0] ev_cf,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          err_any
);

    localparam logic [DW-1:0] SPECIAL_BIT = DW'(1) << SPECIAL;
    localparam logic [DW-1:0] ENG_FORCE   = (REV == 0) ? SPECIAL_BIT : '0;

    logic [NSTK-1:0][DW-1:0] stk_ev, stk_mask, stk_log, stk_new;
    logic [NSTS-1:0][DW-1:0] sts_ev, sts_inj, sts_mask, sts_val;
    logic [DW-1:0]           inj_q;
    logic [INJ_W-1:0]        inj_code;
    logic [DW-1:0]           first_word, next_word;

    assign stk_ev[0] = ev_eng;
    assign stk_ev[1] = ev_lnk0;
    assign stk_ev[2] = ev_lnk1;
    assign inj_code  = inj_q[INJ_W-1:0];
    assign sts_inj[0] = DW'(inj_code[0]);
    assign sts_inj[1] = DW'(inj_code[INJ_W-1:1]);
    assign sts_ev[0]  = ev_nf | sts_inj[0];
    assign sts_ev[1]  = ev_cf | sts_inj[1];

    for (genvar s = 0; s < NSTK; s++) begin : g_stk
        gerr_log #(
            .DW    (DW),
            .FORCE ((s == 0) ? ENG_FORCE : '0)
        ) u_log (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_we  (reg_we && (reg_addr == AW'(stk_mask_addr(s)))),
            .clr_we   (reg_we && (reg_addr == AW'(stk_log_addr(s)))),
            .wdata    (reg_wdata),
            .ev       (stk_ev[s]),
            .mask_q   (stk_mask[s]),
            .log_q    (stk_log[s]),
            .new_bits (stk_new[s])
        );
    end

    for (genvar t = 0; t < NSTS; t++) begin : g_sts
        gerr_stat #(
            .DW (DW)
        ) u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .mask_we (reg_we && (reg_addr == AW'(sts_mask_addr(t)))),
            .wdata   (reg_wdata),
            .ev      (sts_ev[t]),
            .mask_q  (sts_mask[t]),
            .sts_q   (sts_val[t])
        );
    end

    gerr_capture #(
        .DW (DW),
        .NS (NSTK)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_bits   (stk_new),
        .log_q      (stk_log),
        .first_word (first_word),
        .next_word  (next_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_q <= '0;
        end else if (reg_we && (reg_addr == AW'(A_INJ))) begin
            inj_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int s = 0; s < NSTK; s++) begin
            if (reg_addr == AW'(stk_mask_addr(s))) reg_rdata = stk_mask[s];
            if (reg_addr == AW'(stk_log_addr(s)))  reg_rdata = stk_log[s];
        end
        for (int t = 0; t < NSTS; t++) begin
            if (reg_addr == AW'(sts_mask_addr(t))) reg_rdata = sts_mask[t];
            if (reg_addr == AW'(sts_val_addr(t)))  reg_rdata = sts_val[t];
        end
        if (reg_addr == AW'(A_FIRST)) reg_rdata = first_word;
        if (reg_addr == AW'(A_NEXT))  reg_rdata = next_word;
        if (reg_addr == AW'(A_INJ))   reg_rdata = inj_q;
    end

    assign err_any = (|stk_log) | (|sts_val);

endmodule

// File: rtl/gerr_bank_chk.sv
`timescale 1ns/1ps
module gerr_bank_chk #(
    parameter int DW      = 64,
    parameter int REV     = 0,
    parameter int SPECIAL = 6,
    parameter int NS      = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] eng_ev,
    input logic [DW-1:0] eng_mask,
    input logic [DW-1:0] eng_log,
    input logic [DW-1:0] first_word,
    input logic [DW-1:0] next_word,
    input logic          err_any
);

    p_special_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (REV != 0) || eng_mask[SPECIAL]);

    p_event_logged_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eng_ev & ~eng_mask)) |=>
        ((eng_log & $past(eng_ev & ~eng_mask)) == $past(eng_ev & ~eng_mask)));

    p_first_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (first_word != $past(first_word)) |->
        (($past(first_word) == '0) || (first_word == '0)));

    p_next_after_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((next_word != '0) && ($past(next_word) == '0)) |-> ($past(first_word) != '0));

    p_source_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_word[DW-1:DW-NS]));

    p_flag_follows_log_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_log != '0) |-> err_any);

endmodule

bind gerr_bank gerr_bank_chk #(
    .DW      (DW),
    .REV     (REV),
    .SPECIAL (SPECIAL),
    .NS      (gerr_pkg::NSTK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_ev     (ev_eng),
    .eng_mask   (stk_mask[0]),
    .eng_log    (stk_log[0]),
    .first_word (first_word),
    .next_word  (next_word),
    .err_any    (err_any)
);

// File: tb/gerr_bank_bench.sv
`timescale 1ns/1ps
module gerr_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] b_ev [5];
    logic        b_we = 1'b0;
    logic [7:0]  b_addr = 8'h00;
    logic [63:0] b_wdata = '0;
    logic [63:0] b_rdata;
    logic        b_any;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    initial for (int i = 0; i < 5; i++) b_ev[i] = '0;

    gerr_bank u_gerr_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_eng    (b_ev[0]),
        .ev_lnk0   (b_ev[1]),
        .ev_lnk1   (b_ev[2]),
        .ev_nf     (b_ev[3]),
        .ev_cf     (b_ev[4]),
        .reg_we    (b_we),
        .reg_addr  (b_addr),
        .reg_wdata (b_wdata),
        .reg_rdata (b_rdata),
        .err_any   (b_any)
    );

    // ---------------- reference model ----------------
    logic [63:0] m_mask [5];
    logic [63:0] m_log  [5];
    logic [63:0] m_inj;
    bit          fv, nv;
    int          fs, fi, ns_, ni;

    always @(posedge clk) begin : mdl
        logic [63:0] ev [5];
        logic [63:0] hit [5];
        logic [63:0] nb, clr;
        bit any, rf, rn;
        int ps, pi;
        if (!rst_n) begin
            for (int s = 0; s < 5; s++) begin m_mask[s] = '1; m_log[s] = '0; end
            m_inj = '0; fv = 0; nv = 0; fs = 0; fi = 0; ns_ = 0; ni = 0;
        end else begin
            for (int s = 0; s < 5; s++) ev[s] = b_ev[s];
            ev[3] = ev[3] | {63'b0, m_inj[0]};
            ev[4] = ev[4] | {62'b0, m_inj[2:1]};
            for (int s = 0; s < 5; s++) hit[s] = ev[s] & ~m_mask[s];
            any = 0; ps = 0; pi = 0;
            for (int s = 0; s < 3; s++) begin
                if (!any && ((hit[s] & ~m_log[s]) != 0)) begin any = 1; ps = s; end
            end
            if (any) begin
                nb = hit[ps] & ~m_log[ps];
                for (int b = 63; b >= 0; b--) if (nb[b]) pi = b;
            end
            rf = fv && !m_log[fs][fi];
            rn = nv && !m_log[ns_][ni];
            if (fv && nv) begin
                if (rf) fv = 0;
                if (rn) nv = 0;
            end else if (fv) begin
                if (rf) fv = 0;
                else if (any) begin nv = 1; ns_ = ps; ni = pi; end
            end else if (nv) begin
                if (rn) nv = 0;
            end else if (any) begin
                fv = 1; fs = ps; fi = pi;
            end
            for (int s = 0; s < 3; s++) begin
                clr = (b_we && b_addr == 8'(8'h10 + 16 * s)) ? b_wdata : '0;
                m_log[s] = (m_log[s] & ~clr) | hit[s];
                if (b_we && b_addr == 8'(8'h08 + 16 * s))
                    m_mask[s] = b_wdata | ((s == 0) ? 64'h40 : 64'h0);
            end
            for (int s = 3; s < 5; s++) begin
                m_log[s] = hit[s];
                if (b_we && b_addr == 8'(8'h48 + 16 * (s - 3))) m_mask[s] = b_wdata;
            end
            if (b_we && b_addr == 8'h68) m_inj = b_wdata;
        end
    end

    function automatic logic [63:0] cap_word(bit v, int s, int i);
        if (!v) return '0;
        return (64'h1 << (61 + s)) | 64'(i);
    endfunction

    function automatic logic [63:0] exp_rd(logic [7:0] a);
        case (a)
            8'h08: return m_mask[0];
            8'h10: return m_log[0];
            8'h18: return m_mask[1];
            8'h20: return m_log[1];
            8'h28: return m_mask[2];
            8'h30: return m_log[2];
            8'h38: return cap_word(fv, fs, fi);
            8'h40: return cap_word(nv, ns_, ni);
            8'h48: return m_mask[3];
            8'h50: return m_log[3];
            8'h58: return m_mask[4];
            8'h60: return m_log[4];
            8'h68: return m_inj;
            default: return '0;
        endcase
    endfunction

    function automatic string tag(logic [7:0] a);
        case (a)
            8'h08: return "R5";
            8'h18, 8'h28, 8'h48, 8'h58: return "R3";
            8'h10, 8'h20, 8'h30: return "R4";
            8'h38: return "R8/R10";
            8'h40: return "R9/R10";
            8'h50, 8'h60: return "R6";
            8'h68: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [7:0] a, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h t=%0t", req, a, got, exp, $time);
        end
    endtask

    task automatic sweep();
        logic [63:0] e;
        bit any;
        b_we = 1'b0;
        any = 0;
        for (int a = 0; a <= 8'h70; a += 8) begin
            b_addr = 8'(a);
            #0.08;
            e = exp_rd(8'(a));
            check(b_rdata === e, tag(8'(a)), 8'(a), b_rdata, e);
        end
        for (int s = 0; s < 5; s++) if (m_log[s] != 0) any = 1;
        check(b_any === any, "R11", 8'hff, 64'(b_any), 64'(any));
    endtask

    task automatic cyc(bit we, logic [7:0] a, logic [63:0] d,
                       logic [63:0] e0, logic [63:0] e1, logic [63:0] e2,
                       logic [63:0] e3, logic [63:0] e4);
        @(negedge clk);
        if (chk_on) sweep();
        b_we = we; b_addr = a; b_wdata = d;
        b_ev[0] = e0; b_ev[1] = e1; b_ev[2] = e2; b_ev[3] = e3; b_ev[4] = e4;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 8'h00, '0, '0, '0, '0, '0, '0);
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        cyc(1, a, d, '0, '0, '0, '0, '0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, independent of the model
        b_addr = 8'h08; #0.1;
        check(b_rdata === '1, "R1", 8'h08, b_rdata, '1);
        b_addr = 8'h38; #0.1;
        check(b_rdata === '0, "R1", 8'h38, b_rdata, '0);
        check(b_any === 1'b0, "R1", 8'hff, 64'(b_any), 64'h0);
        chk_on = 1'b1;
        idle(2);
        // R3: masked events are dropped
        cyc(0, 8'h00, '0, 64'h5, 64'h5, 64'h5, 64'h5, 64'h5);
        idle(1);
        // R5: try to unmask all engine bits; bit 6 stays masked
        wr(8'h08, '0);
        wr(8'h18, '0);
        wr(8'h28, '0);
        // R8: engine bits 6 (dropped) and 3 together with link1 bit 9
        cyc(0, 8'h00, '0, 64'h48, '0, 64'h200, '0, '0);
        idle(1);
        // R9: link0 bit 20 becomes next
        cyc(0, 8'h00, '0, '0, 64'h100000, '0, '0, '0);
        idle(1);
        // R4: clear engine bit 3 while it fires again: set wins
        cyc(1, 8'h10, 64'h8, 64'h8, '0, '0, '0, '0);
        idle(1);
        // R10: clear engine bit 3 -> first released, next still held
        wr(8'h10, 64'h8);
        idle(2);
        // R10: new events while only next held are not captured
        cyc(0, 8'h00, '0, 64'h1, '0, 64'h4, '0, '0);
        idle(1);
        // release next, then clear remaining logs by write-back
        wr(8'h20, 64'h100000);
        wr(8'h30, 64'h204);
        wr(8'h10, 64'h1);
        idle(2);
        // R8: simultaneous link0 and link1 new bits; link0 wins, no next
        cyc(0, 8'h00, '0, '0, 64'h80, 64'h4, '0, '0);
        idle(2);
        wr(8'h20, 64'h80);
        wr(8'h30, 64'h4);
        idle(2);
        // R6 R7: injection with masks still set, then unmasked
        wr(8'h68, 64'hABCD_0000_1234_0007);
        idle(1);
        wr(8'h48, '0);
        wr(8'h58, '0);
        idle(2);
        // R6: writes to status registers are ignored
        wr(8'h50, '1);
        wr(8'h60, '1);
        cyc(0, 8'h00, '0, '0, '0, '0, 64'hF0, 64'h8000_0000_0000_0000);
        idle(1);
        wr(8'h68, 64'h2);
        idle(2);
        wr(8'h68, '0);
        idle(2);
        // R2: unmapped writes change nothing
        wr(8'h00, '1);
        wr(8'h70, '1);
        idle(1);
        // mixed traffic
        for (int k = 0; k < 600; k++) begin
            logic [63:0] e [5];
            logic [7:0] a;
            for (int s = 0; s < 5; s++)
                e[s] = ($urandom % 7 == 0) ? (64'h1 << ($urandom % 64)) : '0;
            a = 8'(($urandom % 14) * 8);
            if ($urandom % 3 == 0)
                cyc(1, a, (a >= 8'h10 && a <= 8'h30) ? exp_rd(a) :
                          ((a == 8'h68) ? 64'($urandom % 8) : 64'({$urandom, $urandom} & {$urandom, $urandom})),
                    e[0], e[1], e[2], e[3], e[4]);
            else
                cyc(0, 8'h00, '0, e[0], e[1], e[2], e[3], e[4]);
        end
        idle(2);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 got=hang exp=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule